// File: doc/BRIEF.md
# Scan-Wide Sample-Hold Control Generator

This block produces the control level for an external simultaneous sample-and-hold stage during a multi-channel acquisition scan. It watches conversion-start and conversion-done pulses from a scan sequencer, each tagged with a channel index. When conversion of channel 0 starts, it takes the hold condition. It keeps that condition until the conversion-done pulse for a programmable last channel arrives. This way every channel of the scan is digitised from the same captured instant.

A small register interface sets four things: the last channel of the scan, a scan enable, the electrical polarity of the hold level and the source of a shared output pin. The pin carries either the hold level or an incoming DAC pacer clock. The pin is registered, so changing its source or polarity takes effect only on a clock edge. A write to the control register can also abort a scan in progress.

Top module: `shold_gen`

## Requirements
- R1: After reset, hold_active and ssh_pin are 0. Both registers read back as 0, which means scan disabled, active-high hold, pin driven by hold, and last channel 0.
- R2: While idle and enabled, a conv_start pulse with conv_chan equal to 0 sets hold_active in the next cycle. A conv_start with a nonzero channel, or any conv_start while the scan enable is 0, leaves hold_active at 0.
- R3: While holding, conv_done pulses for channels other than the last channel leave hold_active at 1.
- R4: While holding, a conv_done pulse whose conv_chan equals the last-channel register clears hold_active in the next cycle.
- R5: With a last-channel value of 0, hold_active is 1 from the cycle after the channel-0 start until the cycle after the channel-0 done, and is then 0.
- R6: A write to the control register (address 0) that has bit 3 (abort) set, or that has bit 0 (enable) clear, clears hold_active in the next cycle.
- R7: With control bit 2 at 0, ssh_pin equals hold_active XOR control bit 1 (1 means active-low), delayed by one clock.
- R8: With control bit 2 at 1, ssh_pin equals dac_pacer_in delayed by one clock, whatever the hold state.
- R9: Address 0 reads {0, bit2 pin source, bit1 polarity, bit0 enable}, and the abort bit always reads 0. Address 1 reads the last-channel index. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data (combinational) |
| conv_start | input | 1 | Conversion-start pulse from sequencer |
| conv_done | input | 1 | Conversion-done pulse from sequencer |
| conv_chan | input | CH_W | Channel index for the current pulse |
| dac_pacer_in | input | 1 | DAC pacer clock to be routed to the pin |
| hold_active | output | 1 | Logical hold state, active high |
| ssh_pin | output | 1 | Registered shared output pin |

## Verification
The bench covers three ways a scan can end and checks what happens at each boundary. If the design released hold at every done pulse, it would drop hold after channel 0 of a four-channel scan. If it ignored the channel tag on start, it would enter hold on a stray channel-2 start. If it used a last-channel value of 0 as "never end", it would stay in hold forever in single-channel mode. An abort or a disable in the middle of a scan must drop hold on the next edge, and a design that waited for the scan end would be caught there. For the pin, the bench checks the one-cycle lag under both polarities and under the pacer source. It also checks that an active scan does not leak onto the pin while the pacer source is selected.

// File: rtl/shold_pkg.sv
package shold_pkg;

    localparam int REG_AW = 2;

    localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_LAST = 2'd1;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_LOW_BIT   = 1;
    localparam int CTRL_PACER_BIT = 2;
    localparam int CTRL_ABORT_BIT = 3;

    typedef enum logic {
        TRK_IDLE = 1'b0,
        TRK_HOLD = 1'b1
    } trk_state_e;

    typedef struct packed {
        logic pin_pacer;
        logic hold_low;
        logic scan_en;
    } ssh_cfg_t;

    function automatic logic hold_level(input logic hold, input logic low);
        return hold ^ low;
    endfunction

endpackage

// File: rtl/shold_cfg_regs.sv
module shold_cfg_regs
    import shold_pkg::*;
#(
    parameter int CH_W   = 4,
    parameter int DATA_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [REG_AW-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output ssh_cfg_t            cfg,
    output logic [CH_W-1:0]     last_idx,
    output logic                kill
);

    logic ctrl_wr;

    assign ctrl_wr = we && (addr == ADDR_CTRL);
    // Abort strobe or clearing enable ends any scan at this same edge
    assign kill    = ctrl_wr && (wdata[CTRL_ABORT_BIT] || !wdata[CTRL_EN_BIT]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            last_idx <= '0;
        end else if (we) begin
            case (addr)
                ADDR_CTRL: begin
                    cfg.scan_en   <= wdata[CTRL_EN_BIT];
                    cfg.hold_low  <= wdata[CTRL_LOW_BIT];
                    cfg.pin_pacer <= wdata[CTRL_PACER_BIT];
                end
                ADDR_LAST: last_idx <= wdata[CH_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_CTRL: begin
                rdata[CTRL_EN_BIT]    = cfg.scan_en;
                rdata[CTRL_LOW_BIT]   = cfg.hold_low;
                rdata[CTRL_PACER_BIT] = cfg.pin_pacer;
            end
            ADDR_LAST: rdata[CH_W-1:0] = last_idx;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/shold_scan_tracker.sv
module shold_scan_tracker
    import shold_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            scan_en,
    input  logic            kill,
    input  logic            conv_start,
    input  logic            conv_done,
    input  logic [CH_W-1:0] conv_chan,
    input  logic [CH_W-1:0] last_idx,
    output logic            hold
);

    trk_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            TRK_IDLE: begin
                if (scan_en && !kill && conv_start && (conv_chan == '0))
                    state_d = TRK_HOLD;
            end
            TRK_HOLD: begin
                if (kill || !scan_en)
                    state_d = TRK_IDLE;
                else if (conv_done && (conv_chan == last_idx))
                    state_d = TRK_IDLE;
            end
            default: state_d = TRK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= TRK_IDLE;
        else     state_q <= state_d;
    end

    assign hold = (state_q == TRK_HOLD);

endmodule

// File: rtl/shold_pin_mux.sv
module shold_pin_mux
    import shold_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic hold_low,
    input  logic pin_pacer,
    input  logic pacer_in,
    output logic pin_q
);

    logic pin_d;

    assign pin_d = pin_pacer ? pacer_in : hold_level(hold, hold_low);

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b0;
        else     pin_q <= pin_d;
    end

endmodule

// File: rtl/shold_gen.sv
module shold_gen
    import shold_pkg::*;
#(
    parameter int CH_W   = 4,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              conv_start,
    input  logic              conv_done,
    input  logic [CH_W-1:0]   conv_chan,
    input  logic              dac_pacer_in,
    output logic              hold_active,
    output logic              ssh_pin
);

    ssh_cfg_t        cfg;
    logic [CH_W-1:0] last_idx;
    logic            kill;

    shold_cfg_regs #(.CH_W(CH_W), .DATA_W(DATA_W)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .cfg      (cfg),
        .last_idx (last_idx),
        .kill     (kill)
    );

    shold_scan_tracker #(.CH_W(CH_W)) trk_i (
        .clk        (clk),
        .rst        (rst),
        .scan_en    (cfg.scan_en),
        .kill       (kill),
        .conv_start (conv_start),
        .conv_done  (conv_done),
        .conv_chan  (conv_chan),
        .last_idx   (last_idx),
        .hold       (hold_active)
    );

    shold_pin_mux pin_i (
        .clk       (clk),
        .rst       (rst),
        .hold      (hold_active),
        .hold_low  (cfg.hold_low),
        .pin_pacer (cfg.pin_pacer),
        .pacer_in  (dac_pacer_in),
        .pin_q     (ssh_pin)
    );

endmodule

// File: rtl/shold_gen_chk.sv
module shold_gen_chk
    import shold_pkg::*;
#(
    parameter int CH_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            conv_start,
    input logic            conv_done,
    input logic [CH_W-1:0] conv_chan,
    input logic            dac_pacer_in,
    input logic            hold_active,
    input logic            ssh_pin,
    input ssh_cfg_t        cfg,
    input logic [CH_W-1:0] last_idx,
    input logic            kill
);

    assert_hold_rise_R2: assert property (@(posedge clk) disable iff (rst)
        (!hold_active && cfg.scan_en && !kill && conv_start && conv_chan == '0)
        |=> hold_active);

    assert_idle_ignore_R2: assert property (@(posedge clk) disable iff (rst)
        (!hold_active && !(conv_start && conv_chan == '0)) |=> !hold_active);

    assert_hold_keep_R3: assert property (@(posedge clk) disable iff (rst)
        (hold_active && cfg.scan_en && !kill && !(conv_done && conv_chan == last_idx))
        |=> hold_active);

    assert_hold_release_R4: assert property (@(posedge clk) disable iff (rst)
        (hold_active && conv_done && conv_chan == last_idx) |=> !hold_active);

    assert_kill_drop_R6: assert property (@(posedge clk) disable iff (rst)
        kill |=> !hold_active);

    assert_pin_level_R7: assert property (@(posedge clk) disable iff (rst)
        !cfg.pin_pacer |=> (ssh_pin == ($past(hold_active) ^ $past(cfg.hold_low))));

    assert_pin_pacer_R8: assert property (@(posedge clk) disable iff (rst)
        cfg.pin_pacer |=> (ssh_pin == $past(dac_pacer_in)));

endmodule

bind shold_gen shold_gen_chk #(.CH_W(CH_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .conv_start   (conv_start),
    .conv_done    (conv_done),
    .conv_chan    (conv_chan),
    .dac_pacer_in (dac_pacer_in),
    .hold_active  (hold_active),
    .ssh_pin      (ssh_pin),
    .cfg          (cfg),
    .last_idx     (last_idx),
    .kill         (kill)
);

// File: tb/shold_gen_tb_top.sv
module shold_gen_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  CH_W   = 4;
    localparam int  DATA_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_addr = '0;
    logic [DATA_W-1:0] cfg_wdata = '0;
    logic [DATA_W-1:0] cfg_rdata;
    logic              conv_start = 1'b0;
    logic              conv_done = 1'b0;
    logic [CH_W-1:0]   conv_chan = '0;
    logic              dac_pacer_in = 1'b0;
    logic              hold_active;
    logic              ssh_pin;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shold_gen #(.CH_W(CH_W), .DATA_W(DATA_W)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .conv_start   (conv_start),
        .conv_done    (conv_done),
        .conv_chan    (conv_chan),
        .dac_pacer_in (dac_pacer_in),
        .hold_active  (hold_active),
        .ssh_pin      (ssh_pin)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        cfg_addr = a;
        #1;
        v = int'(cfg_rdata);
    endtask

    task automatic start_pulse(input int ch);
        @(negedge clk);
        conv_start = 1'b1; conv_chan = CH_W'(ch);
        @(negedge clk);
        conv_start = 1'b0;
    endtask

    task automatic done_pulse(input int ch);
        @(negedge clk);
        conv_done = 1'b1; conv_chan = CH_W'(ch);
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic t_reset();
        int v;
        check("R1", "hold after reset", int'(hold_active), 0);
        check("R1", "pin after reset", int'(ssh_pin), 0);
        rd(2'd0, v); check("R1", "ctrl after reset", v, 0);
        rd(2'd1, v); check("R1", "last after reset", v, 0);
    endtask

    task automatic t_multi_scan();
        wr(2'd1, 4'd3);
        wr(2'd0, 4'h1);
        start_pulse(0);
        check("R2", "hold after ch0 start", int'(hold_active), 1);
        check("R7", "pin lags hold", int'(ssh_pin), 0);
        @(negedge clk);
        check("R7", "pin one cycle later", int'(ssh_pin), 1);
        for (int ch = 0; ch < 3; ch++) begin
            done_pulse(ch);
            check("R3", "hold after mid-scan done", int'(hold_active), 1);
            if (ch < 2) start_pulse(ch + 1);
        end
        start_pulse(3);
        done_pulse(3);
        check("R4", "hold after last done", int'(hold_active), 0);
        @(negedge clk);
        check("R7", "pin released", int'(ssh_pin), 0);
    endtask

    task automatic t_ignore();
        start_pulse(2);
        check("R2", "nonzero start ignored", int'(hold_active), 0);
        wr(2'd0, 4'h0);
        start_pulse(0);
        check("R2", "start ignored when disabled", int'(hold_active), 0);
    endtask

    task automatic t_single();
        wr(2'd1, 4'd0);
        wr(2'd0, 4'h1);
        start_pulse(0);
        check("R5", "single hold set", int'(hold_active), 1);
        @(negedge clk);
        check("R5", "single hold kept while converting", int'(hold_active), 1);
        done_pulse(0);
        check("R5", "single hold released", int'(hold_active), 0);
    endtask

    task automatic t_abort();
        int v;
        wr(2'd1, 4'd3);
        wr(2'd0, 4'h1);
        start_pulse(0);
        check("R6", "hold before abort", int'(hold_active), 1);
        wr(2'd0, 4'h9);
        check("R6", "hold after abort", int'(hold_active), 0);
        rd(2'd0, v); check("R9", "abort bit reads 0", v, 1);
        start_pulse(0);
        check("R6", "hold before disable", int'(hold_active), 1);
        wr(2'd0, 4'h0);
        check("R6", "hold after disable", int'(hold_active), 0);
    endtask

    task automatic t_polarity();
        wr(2'd0, 4'h3);
        @(negedge clk);
        check("R7", "active-low idle pin", int'(ssh_pin), 1);
        start_pulse(0);
        check("R7", "active-low pin lags", int'(ssh_pin), 1);
        @(negedge clk);
        check("R7", "active-low pin in hold", int'(ssh_pin), 0);
        wr(2'd0, 4'hB);
        @(negedge clk);
        check("R7", "active-low pin after abort", int'(ssh_pin), 1);
    endtask

    task automatic t_pacer();
        wr(2'd0, 4'h4);
        @(negedge clk);
        dac_pacer_in = 1'b1;
        @(negedge clk);
        check("R8", "pin follows pacer high", int'(ssh_pin), 1);
        dac_pacer_in = 1'b0;
        @(negedge clk);
        check("R8", "pin follows pacer low", int'(ssh_pin), 0);
        wr(2'd0, 4'h5);
        start_pulse(0);
        @(negedge clk);
        check("R8", "hold active", int'(hold_active), 1);
        check("R8", "pin ignores hold", int'(ssh_pin), 0);
        wr(2'd0, 4'h0);
    endtask

    task automatic t_readback();
        int v;
        wr(2'd1, 4'd5);
        rd(2'd1, v); check("R9", "last readback", v, 5);
        wr(2'd0, 4'h6);
        rd(2'd0, v); check("R9", "ctrl readback", v, 6);
        rd(2'd2, v); check("R9", "unmapped read", v, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_multi_scan();
        t_ignore();
        t_single();
        t_abort();
        t_polarity();
        t_pacer();
        t_readback();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule